// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block sits in front of a 10-bit digital-to-analog converter. It holds the code as two byte-wide data registers on a small 8-bit bus. The bus has a one-bit address, a write strobe, write data and a combinational read-data return. The bus can never reach the code that the converter actually sees. That code sits in a separate shadow register. The shadow is loaded from the two data registers as a whole, so the converter never sees a code that is half old and half new.

A mode input selects when the shadow is loaded. In direct mode, a write to the high byte loads the shadow at once. The load uses the new high byte and the stored low byte. In triggered mode, a write to the high byte arms the block. From then on, every rising edge on one of eight hardware trigger inputs reloads the shadow, until a write to the low byte disarms it. A 3-bit select input chooses which trigger input counts. An alignment input chooses between two layouts: the code right-aligned across the two bytes, or left-aligned. A one-cycle strobe marks every shadow load.

Top module: `dac_dbuf_regs`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_upd` is 0, and both data registers read back 0.
- R2: With `auto_trig_en` low, a write to the high byte (address 1) loads `dac_code` from the written byte and the stored low byte. The new code and a `dac_upd` pulse are both visible in the cycle after the write.
- R3: A write to the low byte (address 0) never changes `dac_code` and never raises `dac_upd`, in either mode.
- R4: Writing the low byte and then the high byte gives the full 10-bit code from both writes.
- R5: With `auto_trig_en` high, a write to the high byte does not load the shadow. After it, the next rising edge on the selected trigger loads the shadow, with the code and strobe visible in the following cycle.
- R6: A write to the low byte disarms the trigger path. Trigger edges after it do not load the shadow until the high byte is written again.
- R7: Once armed, the block stays armed. Every later rising edge on the selected trigger reloads the shadow, which serves 8-bit use with only high-byte writes.
- R8: Only a rising edge counts, and only on input `trig_in[trig_sel]`. Edges on other inputs have no effect, and a trigger held high does not reload again.
- R9: With `left_adj` = 1, the code is {high[7:0], low[7:6]}, and low-byte bits 5..0 read back as 0.
- R10: With `left_adj` = 0, the code is {high[1:0], low[7:0]}, and high-byte bits 7..2 read back as 0.
- R11: `dac_upd` is high for exactly one cycle per shadow load, and `dac_code` changes only in a cycle where `dac_upd` is high.
- R12: `bus_rdata` returns the low byte when `bus_addr` is 0 and the high byte when it is 1, masked as in R9/R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 low byte, 1 high byte |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| auto_trig_en | input | 1 | 1: shadow loads on trigger edges; 0: on high-byte write |
| trig_sel | input | 3 | Index of the trigger input in use |
| trig_in | input | 8 | Hardware trigger inputs |
| left_adj | input | 1 | 1: left-aligned code layout; 0: right-aligned |
| dac_code | output | 10 | Shadow code sent to the converter |
| dac_upd | output | 1 | One-cycle pulse on every shadow load |

## Verification
The hardest state to reach from the ports is triggered mode. There, whether a trigger edge loads depends on the order of the earlier byte writes, and that order is not visible at the ports. Rising edges also have to land on the selected input rather than on a neighbour. The random stimulus mixes low writes, high writes, trigger pulses on random inputs, changes of select and mode, and long-held trigger levels. A bench model tracks the armed state. Directed sequences first cover arming, disarming by a low write, repeated reloads while armed, and a held trigger.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
   localparam logic ADDR_LOW  = 1'b0;
   localparam logic ADDR_HIGH = 1'b1;

   typedef enum logic {
      ALIGN_RIGHT = 1'b0,
      ALIGN_LEFT  = 1'b1
   } align_e;
endpackage

// File: rtl/dac_data_regs.sv
// Holds the two byte registers, assembles code words and serves reads.
module dac_data_regs #(
   parameter int BUS_W  = 8,
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              rd_addr,
   input  logic              left_adj,
   output logic [BUS_W-1:0]  rdata,
   output logic [CODE_W-1:0] code_regs,
   output logic [CODE_W-1:0] code_with_new_hi
);
   import dac_dbuf_pkg::*;

   localparam int EXTRA = CODE_W - BUS_W;
   localparam logic [BUS_W-1:0] ONES          = {BUS_W{1'b1}};
   localparam logic [BUS_W-1:0] LO_LEFT_MASK  = ~(ONES >> EXTRA);
   localparam logic [BUS_W-1:0] HI_RIGHT_MASK = ONES >> (BUS_W - EXTRA);

   if (EXTRA < 1 || EXTRA > BUS_W) begin : g_bad_width
      $error("dac_data_regs: CODE_W must lie in BUS_W+1 .. 2*BUS_W");
   end

   logic [BUS_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) hi_q <= wdata;
      end
   end

   function automatic logic [CODE_W-1:0] join_code(
      input logic [BUS_W-1:0] hi, input logic [BUS_W-1:0] lo, input logic la);
      if (align_e'(la) == ALIGN_LEFT) join_code = {hi, lo[BUS_W-1 -: EXTRA]};
      else                            join_code = {hi[EXTRA-1:0], lo};
   endfunction

   always_comb begin
      code_regs        = join_code(hi_q, lo_q, left_adj);
      code_with_new_hi = join_code(wdata, lo_q, left_adj);
   end

   always_comb begin
      if (rd_addr == ADDR_HIGH)
         rdata = (align_e'(left_adj) == ALIGN_LEFT) ? hi_q : (hi_q & HI_RIGHT_MASK);
      else
         rdata = (align_e'(left_adj) == ALIGN_LEFT) ? (lo_q & LO_LEFT_MASK) : lo_q;
   end

   // R12: a read of the high byte in left layout returns what was last written there
   a_r12_hi_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && left_adj) |=> (!left_adj || rd_addr != ADDR_HIGH || rdata == $past(wdata)) || wr_hi);
endmodule

// File: rtl/dac_trig_detect.sv
// Rising-edge detection on every trigger input, then selection of one.
module dac_trig_detect #(
   parameter int NUM_TRIG = 8,
   localparam int SEL_W   = $clog2(NUM_TRIG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIG-1:0] trig_in,
   input  logic [SEL_W-1:0]    trig_sel,
   output logic                trig_evt
);
   if (NUM_TRIG < 2 || (1 << SEL_W) != NUM_TRIG) begin : g_bad_count
      $error("dac_trig_detect: NUM_TRIG must be a power of two, at least 2");
   end

   logic [NUM_TRIG-1:0] rise;

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= trig_in[i];
      end
      assign rise[i] = trig_in[i] & ~prev_q;
   end

   assign trig_evt = rise[trig_sel];

   // R8: an event needs the selected line high now
   a_r8_event_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |-> trig_in[trig_sel]);
   // R8: a line held high over two cycles produces no second event on it
   a_r8_no_event_on_level: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in[trig_sel] && $stable(trig_sel)) |=> (!trig_evt || !$stable(trig_sel) || !trig_in[trig_sel] || !$past(trig_in[trig_sel]) ? 1'b1 : 1'b1) && !(trig_evt && $stable(trig_sel) && $past(trig_in[trig_sel])));
endmodule

// File: rtl/dac_xfer_ctrl.sv
// Arming state, shadow code register and load strobe.
module dac_xfer_ctrl #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              trig_evt,
   input  logic [CODE_W-1:0] code_regs,
   input  logic [CODE_W-1:0] code_with_new_hi,
   output logic [CODE_W-1:0] code_q,
   output logic              upd_q
);
   logic armed_q;
   logic load_direct, load_trig;

   assign load_direct = !auto_en && wr_hi;
   assign load_trig   = auto_en && armed_q && trig_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else if (wr_hi) armed_q <= 1'b1;
      else if (wr_lo) armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load_direct || load_trig;
         if (load_direct)    code_q <= code_with_new_hi;
         else if (load_trig) code_q <= code_regs;
      end
   end

   // R5: in triggered mode nothing loads while disarmed
   a_r5_unarmed_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && !armed_q) |=> !upd_q);
   // R6: a low write leaves the path disarmed
   a_r6_low_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !armed_q);
endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs #(
   parameter int BUS_W    = 8,
   parameter int CODE_W   = 10,
   parameter int NUM_TRIG = 8,
   localparam int SEL_W   = $clog2(NUM_TRIG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_addr,
   input  logic                bus_we,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic                auto_trig_en,
   input  logic [SEL_W-1:0]    trig_sel,
   input  logic [NUM_TRIG-1:0] trig_in,
   input  logic                left_adj,
   output logic [CODE_W-1:0]   dac_code,
   output logic                dac_upd
);
   import dac_dbuf_pkg::*;

   logic wr_lo, wr_hi, trig_evt;
   logic [CODE_W-1:0] code_regs, code_with_new_hi;

   assign wr_lo = bus_we && (bus_addr == ADDR_LOW);
   assign wr_hi = bus_we && (bus_addr == ADDR_HIGH);

   dac_data_regs #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
      .rd_addr(bus_addr), .left_adj(left_adj), .rdata(bus_rdata),
      .code_regs(code_regs), .code_with_new_hi(code_with_new_hi));

   dac_trig_detect #(.NUM_TRIG(NUM_TRIG)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
      .trig_evt(trig_evt));

   dac_xfer_ctrl #(.CODE_W(CODE_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_trig_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .trig_evt(trig_evt), .code_regs(code_regs), .code_with_new_hi(code_with_new_hi),
      .code_q(dac_code), .upd_q(dac_upd));

   // R2: direct mode, a high write produces a strobe next cycle
   a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !auto_trig_en) |=> dac_upd);
   // R3: a low write with no trigger path active leaves the code alone
   a_r3_low_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !auto_trig_en) |=> ($stable(dac_code) && !dac_upd));
   // R11: the code only moves together with the strobe
   a_r11_code_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_upd |-> $stable(dac_code));
endmodule

// File: tb/dac_dbuf_regs_test.sv
module dac_dbuf_regs_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       auto_trig_en = 1'b0;
   logic [2:0] trig_sel = '0;
   logic [7:0] trig_in = '0;
   logic       left_adj = 1'b0;
   logic [9:0] dac_code;
   logic       dac_upd;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [7:0] m_hi = '0, m_lo = '0;
   logic       m_armed = 1'b0;
   logic [9:0] m_code = '0;

   always #10 clk = ~clk;

   dac_dbuf_regs uut (.*);

   function automatic logic [9:0] f_code(logic [7:0] hi, logic [7:0] lo, logic la);
      return la ? {hi, lo[7:6]} : {hi[1:0], lo};
   endfunction

   function automatic logic [7:0] f_rd(logic a, logic [7:0] hi, logic [7:0] lo, logic la);
      if (a) return la ? hi : (hi & 8'h03);
      return la ? (lo & 8'hC0) : lo;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_out(string tag, bit exp_upd);
      chk(dac_code == m_code, {tag, " code"}, dac_code, m_code);
      chk(dac_upd == exp_upd, {tag, " strobe"}, dac_upd, exp_upd);
   endtask

   task automatic chk_rd(string tag, logic a);
      bus_addr = a;
      #1;
      chk(bus_rdata == f_rd(a, m_hi, m_lo, left_adj), tag, bus_rdata, f_rd(a, m_hi, m_lo, left_adj));
   endtask

   // one bus write, then check outputs in the following cycle
   task automatic wr(logic a, logic [7:0] d, string tag);
      bit ld = 1'b0;
      if (a) begin
         if (!auto_trig_en) begin ld = 1'b1; m_code = f_code(d, m_lo, left_adj); end
         m_hi = d; m_armed = 1'b1;
      end else begin
         m_lo = d; m_armed = 1'b0;
      end
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      chk_out(tag, ld);
   endtask

   // pulse a trigger line for one cycle, check load then check quiet cycle
   task automatic pulse(int ch, string tag);
      bit ld = auto_trig_en && m_armed && (ch == int'(trig_sel));
      if (ld) m_code = f_code(m_hi, m_lo, left_adj);
      trig_in[ch] = 1'b1;
      @(posedge clk); @(negedge clk);
      chk_out(tag, ld);
      trig_in[ch] = 1'b0;
      @(posedge clk); @(negedge clk);
      chk_out({tag, " after"}, 1'b0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_out("R1 in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_out("R1 after reset", 1'b0);
      chk_rd("R1 low reads 0", 1'b0);
      chk_rd("R1 high reads 0", 1'b1);

      // R10 right layout, R4 ordered write, R2 direct load
      left_adj = 1'b0;
      wr(1'b0, 8'hA5, "R3 low write no change");
      wr(1'b1, 8'hFE, "R2 R4 R10 direct load");
      chk(dac_code == 10'h2A5, "R10 right layout code", dac_code, 10'h2A5);
      chk_rd("R10 high masked", 1'b1);
      chk_rd("R12 low readback", 1'b0);
      @(negedge clk);
      chk_out("R11 strobe one cycle", 1'b0);

      // R9 left layout
      left_adj = 1'b1;
      wr(1'b0, 8'h7F, "R3 low write left");
      wr(1'b1, 8'h81, "R9 direct load left");
      chk(dac_code == 10'h205, "R9 left layout code", dac_code, 10'h205);
      chk_rd("R9 low masked", 1'b0);
      chk_rd("R12 high readback", 1'b1);

      // triggered mode
      auto_trig_en = 1'b1; trig_sel = 3'd5;
      wr(1'b0, 8'h40, "R6 low disarms");
      pulse(5, "R6 disarmed trigger ignored");
      wr(1'b1, 8'h3C, "R5 high write no load");
      pulse(2, "R8 other input ignored");
      pulse(5, "R5 armed trigger loads");
      wr(1'b1, 8'h11, "R7 8-bit high write");
      pulse(5, "R7 reload 1");
      pulse(5, "R7 reload 2");
      // R8 held level: one load only
      m_code = f_code(m_hi, m_lo, left_adj);
      trig_in[5] = 1'b1;
      @(posedge clk); @(negedge clk);
      chk_out("R8 first edge", 1'b1);
      repeat (3) begin
         @(posedge clk); @(negedge clk);
         chk_out("R8 held level no reload", 1'b0);
      end
      trig_in[5] = 1'b0;
      @(posedge clk); @(negedge clk);
      wr(1'b0, 8'hFF, "R3 low write in trig mode");
      pulse(5, "R6 trigger after low write");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op = $urandom_range(0, 9);
         case (op)
            0, 1: wr(1'b0, 8'($urandom), "R3 R6 random low write");
            2, 3: wr(1'b1, 8'($urandom), "R2 R5 random high write");
            4, 5, 6: pulse($urandom_range(0, 7), "R5 R7 R8 random trigger");
            7: begin trig_sel = 3'($urandom); @(posedge clk); @(negedge clk); chk_out("R11 sel change", 1'b0); end
            8: begin auto_trig_en = 1'($urandom); @(posedge clk); @(negedge clk); chk_out("R11 mode change", 1'b0); end
            default: begin
               left_adj = 1'($urandom);
               chk_rd("R12 random read low", 1'b0);
               chk_rd("R12 random read high", 1'b1);
            end
         endcase
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule